// File: doc/BRIEF.md
# Control-Register Access Gate

This block sits between instruction decode and a bank of control registers. Each request names a 12-bit register number, the privilege level the hart is running at, an access kind and a source operand. The block decides whether the access is allowed. The number itself carries the access rules: two bits give the lowest privilege that may touch the register, and two more mark it read-only. Reads of the user counter window are gated further by two enable registers, one owned by machine level and one by supervisor level.

For an allowed access the block returns the previous contents of the register. When the access carries a non-zero write mask, it merges the operand into the old value and writes the result back, announcing the write on a strobe. A refused access raises an illegal-instruction flag and returns zero. The register bank behind the gate is a stand-in. It holds the two enable registers, a small scratch array, a read-only identity word and a counter window that reads back its own index.

Top module: `csr_gate`

## Requirements
- R1: Privilege levels are encoded user=0, supervisor=1, machine=3. An access whose privilege is numerically below bits 9:8 of the register number is illegal.
- R2: A register whose number has bits 11:10 equal to 3 is read-only. An access to it with a non-zero write mask is illegal, and a zero-mask access to it is legal.
- R3: Access kind 0 is a plain read with mask 0. Kind 1 (swap) uses new value = operand and mask = all ones. Kind 2 (set) uses all ones and the operand as mask. Kind 3 (clear) uses zero and the operand as mask. For kinds 2 and 3 the mask is zero whenever the operand-is-zero flag is set, whatever the operand holds.
- R4: A legal access returns the old value and writes (old & ~mask) | (new & mask).
- R5: Numbers 0xC00 to 0xC1F form the counter window, each reading back its index (bits 4:0). Below machine level, the bit selected by bits 4:0 in the machine counter-enable register (0x306) must be 1 or the access is illegal.
- R6: At user level, the same bit of the supervisor counter-enable register (0x106) must also be 1.
- R7: The implemented numbers are the counter window, 0x306, 0x106, the scratch array (0x340 to 0x343 by default) and the identity word at 0xF14 (value 5 by default). Every other number is illegal.
- R8: No write strobe is issued for a zero mask or for an illegal access, and an illegal access leaves all state unchanged and returns zero data.
- R9: The response is registered one cycle after the request. A write is visible to a request issued in the very next cycle.
- R10: After reset all stored registers are zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_csr | input | 12 | Register number |
| req_priv | input | 2 | Current privilege level |
| req_op | input | 2 | Access kind (read, swap, set, clear) |
| req_src | input | DATA_W | Source operand |
| req_src_zero | input | 1 | Operand comes from the zero register |
| rsp_valid | output | 1 | Response present |
| rsp_illegal | output | 1 | Access refused |
| rsp_rdata | output | DATA_W | Old register value |
| wr_en | output | 1 | A write was performed |
| wr_csr | output | 12 | Number of the written register |
| wr_data | output | DATA_W | Value written |

## Verification
Each result (the legality flag, the old value and the write strobe with its data) is due on the clock edge that follows the request. The bench drives a request on a falling edge and samples all outputs on the next falling edge, which falls half a cycle after that capture edge. Requests are issued back to back, so any write that lands late shows up as a wrong old value in the next sweep entry. The bench keeps its own model of the enable registers and scratch array, derived only from the requirement text, and compares every response with that model.

// File: rtl/csr_gate.sv
module csr_gate #(
  parameter int              DATA_W   = 32,
  parameter int              NREG     = 4,
  parameter logic [11:0]     ARR_BASE = 12'h340,
  parameter logic [11:0]     MCE_CSR  = 12'h306,
  parameter logic [11:0]     SCE_CSR  = 12'h106,
  parameter logic [11:0]     ID_CSR   = 12'hF14,
  parameter logic [DATA_W-1:0] ID_VAL = DATA_W'(5)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [11:0]       req_csr,
  input  logic [1:0]        req_priv,
  input  logic [1:0]        req_op,
  input  logic [DATA_W-1:0] req_src,
  input  logic              req_src_zero,
  output logic              rsp_valid,
  output logic              rsp_illegal,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              wr_en,
  output logic [11:0]       wr_csr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [DATA_W-1:0] mce, sce;
  logic [DATA_W-1:0] regs [NREG];

  logic [DATA_W-1:0] mask, newv, oldv, merged;
  logic [IW-1:0]     arr_idx;
  logic [4:0]        ctr_idx;
  logic              is_ctr, is_arr, is_mce, is_sce, is_id, impl;
  logic              priv_ok, ro_viol, ctr_ok, illegal, do_write;

  assign ctr_idx = req_csr[4:0];
  assign arr_idx = IW'(req_csr - ARR_BASE);
  assign is_ctr  = req_csr[11:5] == 7'b1100000;
  assign is_arr  = (req_csr >= ARR_BASE) && ({1'b0, req_csr} < ({1'b0, ARR_BASE} + 13'(NREG)));
  assign is_mce  = req_csr == MCE_CSR;
  assign is_sce  = req_csr == SCE_CSR;
  assign is_id   = req_csr == ID_CSR;
  assign impl    = is_ctr | is_arr | is_mce | is_sce | is_id;

  always_comb begin
    unique case (req_op)
      2'd0: begin mask = '0;                        newv = '0;      end
      2'd1: begin mask = '1;                        newv = req_src; end
      2'd2: begin mask = req_src_zero ? '0 : req_src; newv = '1;    end
      default: begin mask = req_src_zero ? '0 : req_src; newv = '0; end
    endcase
  end

  always_comb begin
    ctr_ok = 1'b1;
    if (req_priv < 2'd3) ctr_ok = ctr_ok & mce[ctr_idx];
    if (req_priv < 2'd1) ctr_ok = ctr_ok & sce[ctr_idx];
  end

  always_comb begin
    oldv = '0;
    if (is_ctr)      oldv = DATA_W'(ctr_idx);
    else if (is_mce) oldv = mce;
    else if (is_sce) oldv = sce;
    else if (is_id)  oldv = ID_VAL;
    else if (is_arr) oldv = regs[arr_idx];
  end

  assign priv_ok  = req_priv >= req_csr[9:8];
  assign ro_viol  = (req_csr[11:10] == 2'b11) && (mask != '0);
  assign illegal  = !impl || !priv_ok || ro_viol || (is_ctr && !ctr_ok);
  assign merged   = (oldv & ~mask) | (newv & mask);
  assign do_write = req_valid && !illegal && (mask != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mce <= '0;
      sce <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (do_write) begin
      if (is_mce) mce <= merged;
      if (is_sce) sce <= merged;
      if (is_arr) regs[arr_idx] <= merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_illegal <= 1'b0;
      rsp_rdata   <= '0;
      wr_en       <= 1'b0;
      wr_csr      <= '0;
      wr_data     <= '0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_illegal <= req_valid && illegal;
      rsp_rdata   <= (req_valid && !illegal) ? oldv : '0;
      wr_en       <= do_write;
      wr_csr      <= do_write ? req_csr : '0;
      wr_data     <= do_write ? merged : '0;
    end
  end

  a_r1_low_priv_refused: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_priv < req_csr[9:8]) |=> rsp_illegal);

  a_r2_readonly_never_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_csr[11:10] != 2'b11);

  a_r8_plain_read_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 2'd0 |=> !wr_en);

  a_r8_illegal_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal |-> !wr_en && rsp_rdata == '0);

  a_r4_set_bits_present: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 2'd2 && !req_src_zero && req_csr[11:10] != 2'b11 && req_priv == 2'd3
      && req_csr == ARR_BASE |=> !wr_en || ((wr_data & $past(req_src)) == $past(req_src)));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_illegal && !wr_en);
endmodule

// File: tb/test_csr_gate.sv
`timescale 1ns/1ps
module test_csr_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [11:0] req_csr = '0;
  logic [1:0]  req_priv = '0;
  logic [1:0]  req_op = '0;
  logic [31:0] req_src = '0;
  logic        req_src_zero = 1'b0;
  logic        rsp_valid, rsp_illegal, wr_en;
  logic [31:0] rsp_rdata, wr_data;
  logic [11:0] wr_csr;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_mce = '0, m_sce = '0;
  logic [31:0] m_arr [4] = '{default: '0};

  always #4 clk = ~clk;

  csr_gate i_csr_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_csr(req_csr),
    .req_priv(req_priv), .req_op(req_op), .req_src(req_src),
    .req_src_zero(req_src_zero), .rsp_valid(rsp_valid),
    .rsp_illegal(rsp_illegal), .rsp_rdata(rsp_rdata), .wr_en(wr_en),
    .wr_csr(wr_csr), .wr_data(wr_data)
  );

  task automatic access(input logic [11:0] c, input logic [1:0] p, input logic [1:0] op,
                        input logic [31:0] s, input logic sz, input string tag);
    logic [31:0] mask, newv, old, exp_wd;
    logic impl, ill, en, exp_wr;
    bit ok;
    case (op)
      2'd0: begin mask = 0;            newv = 0; end
      2'd1: begin mask = 32'hFFFFFFFF; newv = s; end
      2'd2: begin mask = sz ? 0 : s;   newv = 32'hFFFFFFFF; end
      default: begin mask = sz ? 0 : s; newv = 0; end
    endcase
    old = 0;
    impl = 1'b1;
    if (c >= 12'hC00 && c <= 12'hC1F) old = 32'(c - 12'hC00);
    else if (c == 12'h306) old = m_mce;
    else if (c == 12'h106) old = m_sce;
    else if (c == 12'hF14) old = 32'd5;
    else if (c >= 12'h340 && c <= 12'h343) old = m_arr[c - 12'h340];
    else impl = 1'b0;
    en = 1'b1;
    if (p != 2'd3) en = en & m_mce[c[4:0]];
    if (p == 2'd0) en = en & m_sce[c[4:0]];
    ill = !impl || (p < c[9:8]) || (c[11:10] == 2'b11 && mask != 0)
          || (c >= 12'hC00 && c <= 12'hC1F && !en);
    exp_wr = !ill && mask != 0;
    exp_wd = (old & ~mask) | (newv & mask);

    req_valid = 1'b1; req_csr = c; req_priv = p; req_op = op; req_src = s; req_src_zero = sz;
    @(negedge clk);
    req_valid = 1'b0;
    checks++;
    ok = rsp_valid && rsp_illegal == ill && rsp_rdata == (ill ? 32'd0 : old) && wr_en == exp_wr
         && (!exp_wr || (wr_data == exp_wd && wr_csr == c));
    if (!ok) begin
      fails++;
      $display("FAIL %s csr=%h priv=%0d op=%0d: got ill=%b rd=%h we=%b wd=%h, expected ill=%b rd=%h we=%b wd=%h",
               tag, c, p, op, rsp_illegal, rsp_rdata, wr_en, wr_data,
               ill, ill ? 32'd0 : old, exp_wr, exp_wd);
    end
    if (exp_wr) begin
      if (c == 12'h306) m_mce = exp_wd;
      if (c == 12'h106) m_sce = exp_wd;
      if (c >= 12'h340 && c <= 12'h343) m_arr[c - 12'h340] = exp_wd;
    end
  endtask

  task automatic counter_sweep(input logic [31:0] me, input logic [31:0] se);
    access(12'h306, 2'd3, 2'd1, me, 1'b0, "R5");
    access(12'h106, 2'd1, 2'd1, se, 1'b0, "R6");
    for (int i = 0; i < 32; i++) begin
      access(12'hC00 + 12'(i), 2'd3, 2'd0, 0, 1'b0, "R5");
      access(12'hC00 + 12'(i), 2'd1, 2'd0, 0, 1'b0, "R5");
      access(12'hC00 + 12'(i), 2'd0, 2'd2, 32'h1, 1'b1, "R6");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid || rsp_illegal || wr_en || rsp_rdata != 0) begin
      fails++;
      $display("FAIL R10 reset outputs: valid=%b ill=%b we=%b rd=%h, expected all zero",
               rsp_valid, rsp_illegal, wr_en, rsp_rdata);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R7, R1, R10: read every number at every privilege level
    for (int c = 0; c < 4096; c++) begin
      access(12'(c), 2'd0, 2'd0, 0, 1'b0, "R7");
      access(12'(c), 2'd1, 2'd0, 0, 1'b0, "R1");
      access(12'(c), 2'd3, 2'd0, 0, 1'b0, "R10");
    end

    // R3, R4, R9: merge rules on a scratch register, back to back
    access(12'h340, 2'd3, 2'd1, 32'hA5A5F00F, 1'b0, "R4");
    access(12'h340, 2'd3, 2'd2, 32'h000000F0, 1'b0, "R3");
    access(12'h340, 2'd3, 2'd3, 32'hA0000000, 1'b0, "R3");
    access(12'h340, 2'd3, 2'd2, 32'hFFFFFFFF, 1'b1, "R3");
    access(12'h340, 2'd3, 2'd3, 32'hFFFFFFFF, 1'b1, "R8");
    access(12'h340, 2'd3, 2'd0, 0, 1'b0, "R9");
    access(12'h343, 2'd3, 2'd1, 32'h12345678, 1'b0, "R4");
    access(12'h343, 2'd3, 2'd1, 32'hDEADBEEF, 1'b1, "R3");
    access(12'h343, 2'd3, 2'd0, 0, 1'b0, "R9");
    access(12'h341, 2'd3, 2'd2, 32'h0000FFFF, 1'b0, "R4");
    access(12'h341, 2'd3, 2'd3, 32'h00000F0F, 1'b0, "R4");
    access(12'h341, 2'd3, 2'd0, 0, 1'b0, "R9");

    // R2: read-only numbers
    access(12'hF14, 2'd3, 2'd1, 32'h0, 1'b0, "R2");
    access(12'hF14, 2'd3, 2'd2, 32'h1, 1'b1, "R2");
    access(12'hF14, 2'd3, 2'd2, 32'h1, 1'b0, "R2");
    access(12'hF14, 2'd3, 2'd3, 32'h0, 1'b0, "R2");
    access(12'hF14, 2'd3, 2'd0, 0, 1'b0, "R2");
    access(12'hC03, 2'd3, 2'd1, 32'h7, 1'b0, "R2");

    // R8: refused writes leave state untouched
    access(12'h340, 2'd1, 2'd1, 32'h55555555, 1'b0, "R8");
    access(12'h306, 2'd0, 2'd1, 32'hFFFFFFFF, 1'b0, "R8");
    access(12'h106, 2'd0, 2'd2, 32'hFFFFFFFF, 1'b0, "R8");
    access(12'h340, 2'd3, 2'd0, 0, 1'b0, "R8");
    access(12'h306, 2'd3, 2'd0, 0, 1'b0, "R8");
    access(12'h106, 2'd1, 2'd0, 0, 1'b0, "R8");

    // R5, R6: counter gating under several enable patterns
    counter_sweep(32'hFFFFFFFF, 32'h00000000);
    counter_sweep(32'hF0F03C5A, 32'h0FF0FFFF);
    counter_sweep(32'h00000000, 32'hFFFFFFFF);
    counter_sweep(32'hFFFFFFFF, 32'hFFFFFFFF);
    access(12'h106, 2'd1, 2'd3, 32'h00000008, 1'b0, "R6");
    access(12'hC03, 2'd0, 2'd0, 0, 1'b0, "R6");
    access(12'hC03, 2'd1, 2'd0, 0, 1'b0, "R5");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule